// File: doc/BRIEF.md
# Cascadable Four-Bit Up/Down Counter Stage

This block is one programmable counter stage of four bits. The `DECADE` parameter sets the count range: 0 to 9 for decade use, or 0 to 15 for binary use. A low level on the asynchronous clear input resets the stage at any moment. The other operations act only at the rising clock edge, in this order of priority: synchronous clear, parallel load, and count. A direction input chooses whether the stage counts up or down.

Counting needs two active-low enables at the same time. One of them, the trickle enable, also gates the ripple-carry output. That output is low while the count sits at its terminal value: the top of the range when counting up, or zero when counting down. A second carry output is clocked and goes low only in the low phase of the clock. Stages chain by wiring one stage's ripple carry into the next stage's trickle enable.

The count output can be released to high impedance. The `q_drv` output tells a neighbour whether the stage is driving the bus. The counter keeps running while its output is released.

Top module: `udc_counter`

## Requirements
- R1: While `arst_n` is low, the count is 0. This holds at once, with no clock edge, and whatever the other inputs are.
- R2: When `sclr_n` is low at a rising edge, the count becomes 0. This wins over load and count.
- R3: When `load_n` is low at a rising edge and `sclr_n` is high, the count takes `din`. This wins over count.
- R4: With both clears and load inactive (high), the count steps at a rising edge only when `en_par_n` and `en_trk_n` are both low. Otherwise it holds.
- R5: When `up` is 1 the count increments, and when it is 0 it decrements. The top of the range is 9 when `DECADE` is 1 and 15 when it is 0. Counting up from the top gives 0, and counting down from 0 gives the top.
- R6: In decade mode, a loaded value from 10 to 15 counts up to value+1 modulo 16, so 15 goes to 0. It counts down to value−1. No value locks the counter.
- R7: `rc_n` is 0 exactly when `en_trk_n` is 0 and the count is at its terminal value. The terminal value is 0 when `up` is 0, and the top of the range when `up` is 1.
- R8: `cc_n` is 0 only while `clk` is low, `rc_n` is 0 and `en_par_n` is 0. At all other times it is 1.
- R9: When `oe_n` is 1, `q` is released to high impedance and `q_drv` is 0. When `oe_n` is 0, `q` drives the count and `q_drv` is 1. Counting goes on whatever `oe_n` is.
- R10: Two binary stages form an 8-bit up/down counter when they share clock, controls and enables, and the upper stage's `en_trk_n` comes from the lower stage's `rc_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; operations act on the rising edge |
| arst_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load, active low |
| en_par_n | input | 1 | Parallel count enable, active low |
| en_trk_n | input | 1 | Trickle count enable, active low; also gates `rc_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load data |
| oe_n | input | 1 | Output enable, active low |
| q | output | WIDTH | Count, high impedance when released |
| q_drv | output | 1 | 1 while `q` is driven |
| rc_n | output | 1 | Ripple carry, active low |
| cc_n | output | 1 | Clocked carry, active low during the clock low phase |

## Verification
A wrong next-state value shows on `q` one clock after the faulty edge. A terminal value that is decoded wrongly shows up in two ways, often before the count itself goes wrong: at once on `rc_n`, and on `cc_n` in the following low phase. A wrap fault in decade mode, or a value from 10 to 15 that sticks, shows on `q` at the edge that should leave that value. In the two-stage chain, a carry fault makes the upper nibble go wrong at the first crossing of 15↔0 in the lower stage, so the 8-bit compare flags it in that same cycle.

// File: rtl/udc_pkg.sv
package udc_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STEP  = 2'd3
    } udc_op_e;
endpackage

// File: rtl/udc_op_decode.sv
module udc_op_decode
    import udc_pkg::*;
(
    input  logic    sclr_n,
    input  logic    load_n,
    input  logic    en_par_n,
    input  logic    en_trk_n,
    output udc_op_e op
);
    // Priority: synchronous clear, then load, then count, then hold.
    always_comb begin
        if (!sclr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (!en_par_n && !en_trk_n)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/udc_step.sv
module udc_step #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 16
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

    generate
        if (MODULUS == (1 << WIDTH)) begin : g_full
            // A full binary range wraps by plain overflow.
            always_comb begin
                if (up)
                    nxt = cur + 1'b1;
                else
                    nxt = cur - 1'b1;
            end
        end else begin : g_short
            // A short range wraps explicitly. Codes above TOP keep stepping
            // by one until they leave through natural overflow, so none locks.
            always_comb begin
                if (up)
                    nxt = (cur == TOP) ? '0 : cur + 1'b1;
                else
                    nxt = (cur == '0) ? TOP : cur - 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/udc_carry.sv
module udc_carry #(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 16
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] cnt,
    input  logic             up,
    input  logic             en_par_n,
    input  logic             en_trk_n,
    output logic             rc_n,
    output logic             cc_n
);
    localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

    logic at_term;

    always_comb begin
        at_term = up ? (cnt == TOP) : (cnt == '0);
        rc_n    = !(at_term && !en_trk_n);
        // Gated by the low clock phase. The count changes only at the rising
        // edge, so the terms are steady for the whole low phase.
        cc_n    = !(!clk && !rc_n && !en_par_n);
    end
endmodule

// File: rtl/udc_counter.sv
module udc_counter
    import udc_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             sclr_n,
    input  logic             load_n,
    input  logic             en_par_n,
    input  logic             en_trk_n,
    input  logic             up,
    input  logic [WIDTH-1:0] din,
    input  logic             oe_n,
    output logic [WIDTH-1:0] q,
    output logic             q_drv,
    output logic             rc_n,
    output logic             cc_n
);
    localparam int MODULUS = DECADE ? 10 : (1 << WIDTH);
    localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           state_d, state_q;
    udc_op_e          op;
    logic [WIDTH-1:0] step_val;

    udc_op_decode u_dec (
        .sclr_n   (sclr_n),
        .load_n   (load_n),
        .en_par_n (en_par_n),
        .en_trk_n (en_trk_n),
        .op       (op)
    );

    udc_step #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_step (
        .cur (state_q.cnt),
        .up  (up),
        .nxt (step_val)
    );

    udc_carry #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_carry (
        .clk      (clk),
        .cnt      (state_q.cnt),
        .up       (up),
        .en_par_n (en_par_n),
        .en_trk_n (en_trk_n),
        .rc_n     (rc_n),
        .cc_n     (cc_n)
    );

    always_comb begin
        state_d = state_q;
        case (op)
            OP_CLEAR: state_d.cnt = '0;
            OP_LOAD:  state_d.cnt = din;
            OP_STEP:  state_d.cnt = step_val;
            default:  state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign q_drv = !oe_n;
    assign q     = q_drv ? state_q.cnt : {WIDTH{1'bz}};

    // R2
    sync_clr_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !sclr_n |=> (state_q.cnt == '0));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (sclr_n && !load_n) |=> (state_q.cnt == $past(din)));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (sclr_n && load_n && (en_par_n || en_trk_n)) |=> $stable(state_q.cnt));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (op == OP_STEP && up && state_q.cnt == TOP) |=> (state_q.cnt == '0));

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (op == OP_STEP && !up && state_q.cnt == '0) |=> (state_q.cnt == TOP));
endmodule

// File: tb/udc_counter_test.sv
`timescale 1ns/100ps
module udc_counter_test;
    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       sclr_n = 1'b1, load_n = 1'b1, en_par_n = 1'b1, en_trk_n = 1'b1;
    logic       up = 1'b1, oe_n = 1'b0;
    logic [3:0] din = 4'd0;
    wire  [3:0] q;
    wire        q_drv, rc_n, cc_n;

    // Cascade signals
    logic       cs_load_n = 1'b1, cs_enp_n = 1'b1, cs_ent_n = 1'b1, cs_up = 1'b1;
    logic [7:0] cs_din = 8'd0;
    wire  [3:0] lo_q, hi_q;
    wire        lo_drv, hi_drv, lo_rc_n, hi_rc_n, lo_cc_n, hi_cc_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    udc_counter #(.WIDTH(4), .DECADE(1'b1)) uut (
        .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n),
        .en_par_n(en_par_n), .en_trk_n(en_trk_n), .up(up), .din(din),
        .oe_n(oe_n), .q(q), .q_drv(q_drv), .rc_n(rc_n), .cc_n(cc_n)
    );

    udc_counter #(.WIDTH(4), .DECADE(1'b0)) c_lo (
        .clk(clk), .arst_n(arst_n), .sclr_n(1'b1), .load_n(cs_load_n),
        .en_par_n(cs_enp_n), .en_trk_n(cs_ent_n), .up(cs_up), .din(cs_din[3:0]),
        .oe_n(1'b0), .q(lo_q), .q_drv(lo_drv), .rc_n(lo_rc_n), .cc_n(lo_cc_n)
    );

    udc_counter #(.WIDTH(4), .DECADE(1'b0)) c_hi (
        .clk(clk), .arst_n(arst_n), .sclr_n(1'b1), .load_n(cs_load_n),
        .en_par_n(cs_enp_n), .en_trk_n(lo_rc_n), .up(cs_up), .din(cs_din[7:4]),
        .oe_n(1'b0), .q(hi_q), .q_drv(hi_drv), .rc_n(hi_rc_n), .cc_n(hi_cc_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // {sclr_n, load_n, en_par_n, en_trk_n, up, din[3:0], exp_q[3:0], exp_rc_n}
    localparam int NV = 21;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1,1'b1,1'b1,1'b0,1'b1,4'd0 ,4'd0 ,1'b1}, // R4 hold, enp high
        {1'b1,1'b0,1'b1,1'b1,1'b1,4'd7 ,4'd7 ,1'b1}, // R3 load 7
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd8 ,1'b1}, // R5 up
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd9 ,1'b0}, // R7 terminal up
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd0 ,1'b1}, // R5 wrap 9->0
        {1'b1,1'b1,1'b0,1'b0,1'b0,4'd0 ,4'd9 ,1'b1}, // R5 wrap 0->9
        {1'b1,1'b1,1'b0,1'b0,1'b0,4'd0 ,4'd8 ,1'b1}, // R5 down
        {1'b1,1'b0,1'b0,1'b0,1'b0,4'd1 ,4'd1 ,1'b1}, // R3 load over count
        {1'b1,1'b1,1'b0,1'b0,1'b0,4'd0 ,4'd0 ,1'b0}, // R7 terminal down
        {1'b1,1'b1,1'b1,1'b0,1'b0,4'd0 ,4'd0 ,1'b0}, // R4 hold, R7 rc by ent
        {1'b1,1'b1,1'b0,1'b1,1'b0,4'd0 ,4'd0 ,1'b1}, // R4 hold, R7 ent high
        {1'b1,1'b0,1'b1,1'b1,1'b1,4'd5 ,4'd5 ,1'b1}, // R3 load 5
        {1'b0,1'b0,1'b0,1'b0,1'b1,4'd3 ,4'd0 ,1'b1}, // R2 clear over load
        {1'b1,1'b0,1'b1,1'b1,1'b1,4'd12,4'd12,1'b1}, // R6 load 12
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd13,1'b1}, // R6 up
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd14,1'b1}, // R6 up
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd15,1'b1}, // R6 up
        {1'b1,1'b1,1'b0,1'b0,1'b1,4'd0 ,4'd0 ,1'b1}, // R6 15->0
        {1'b1,1'b0,1'b1,1'b1,1'b0,4'd11,4'd11,1'b1}, // R6 load 11
        {1'b1,1'b1,1'b0,1'b0,1'b0,4'd0 ,4'd10,1'b1}, // R6 down
        {1'b1,1'b1,1'b0,1'b0,1'b0,4'd0 ,4'd9 ,1'b1}  // R6 down into range
    };

    initial begin
        logic [7:0] ref8;
        #6;
        chk("R1 reset q", q, 0);
        chk("R7 reset rc_n", rc_n, 1);
        @(negedge clk);
        arst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {sclr_n, load_n, en_par_n, en_trk_n, up, din} = VEC[i][13:5];
            @(posedge clk);
            #1;
            chk($sformatf("table[%0d] q", i), q, int'(VEC[i][4:1]));
            chk($sformatf("table[%0d] rc_n", i), rc_n, int'(VEC[i][0]));
        end

        // R1: asynchronous clear mid-phase, held against load
        @(negedge clk);
        sclr_n = 1'b1; load_n = 1'b0; din = 4'd6; en_par_n = 1'b1; en_trk_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 load 6", q, 6);
        arst_n = 1'b0;
        #0.5;
        chk("R1 async clear now", q, 0);
        @(posedge clk);
        #1;
        chk("R1 clear holds over load", q, 0);
        @(negedge clk);
        arst_n = 1'b1; load_n = 1'b1;

        // R9: released output, count continues
        oe_n = 1'b1; en_par_n = 1'b0; en_trk_n = 1'b0; up = 1'b1;
        #0.5;
        chk("R9 q_drv released", q_drv, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        oe_n = 1'b0; en_par_n = 1'b1;
        #0.5;
        chk("R9 q_drv driven", q_drv, 1);
        chk("R9 count ran while released", q, 3);

        // R8: clocked carry
        load_n = 1'b0; din = 4'd8; en_trk_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_n = 1'b1; en_par_n = 1'b0; en_trk_n = 1'b0;
        #0.5;
        chk("R8 cc_n high at 8", cc_n, 1);
        @(posedge clk);
        #1;
        chk("R8 q at 9", q, 9);
        chk("R8 cc_n high in high phase", cc_n, 1);
        chk("R7 rc_n at 9 up", rc_n, 0);
        @(negedge clk);
        #0.5;
        chk("R8 cc_n low in low phase", cc_n, 0);
        @(posedge clk);
        #1;
        chk("R8 cc_n high after wrap", cc_n, 1);
        @(negedge clk);
        load_n = 1'b0; din = 4'd9; en_par_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_n = 1'b1;
        #0.5;
        chk("R8 cc_n high with en_par_n high", cc_n, 1);
        chk("R7 rc_n with en_par_n high", rc_n, 0);

        // R10: two-stage 8-bit cascade
        @(negedge clk);
        cs_load_n = 1'b0; cs_din = 8'd250;
        @(posedge clk);
        #1;
        ref8 = 8'd250;
        chk("R10 cascade load", int'({hi_q, lo_q}), int'(ref8));
        @(negedge clk);
        cs_load_n = 1'b1; cs_enp_n = 1'b0; cs_ent_n = 1'b0; cs_up = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            #1;
            ref8 = ref8 + 8'd1;
            chk("R10 cascade up", int'({hi_q, lo_q}), int'(ref8));
        end
        @(negedge clk);
        cs_up = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            #1;
            ref8 = ref8 - 8'd1;
            chk("R10 cascade down", int'({hi_q, lo_q}), int'(ref8));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule